// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit turns the operand fields of one memory instruction into a byte address for a simple processor's load/store path. Each request carries a mode code, a base register value, an index register value, a 16-bit signed displacement, a 32-bit absolute address field, the program counter, an index scale code and an access size. The unit returns the effective address. For the two auto-modify modes it also returns the new base register value and a write-back strobe.

Requests enter through a valid/ready handshake, one per cycle. The result appears in an output register on the cycle after acceptance. The result stays in that register, unchanged, until the consumer takes it. All arithmetic is 32 bits wide and wraps modulo 2^32. A scale code outside the legal range produces an error flag and no write-back.

Top module: `ea_gen`

## Requirements
- R1: Mode code 0 (direct): the address equals the absolute address field.
- R2: Mode code 1 (register indirect): the address equals the base value.
- R3: Mode code 2 (post-increment): the address equals the unmodified base. The write-back strobe is 1 and the write-back value is base plus the step.
- R4: Mode code 3 (pre-decrement): the address and the write-back value both equal base minus the step. The write-back strobe is 1.
- R5: Mode code 4 (displacement): the address equals base plus the sign-extended displacement.
- R6: Mode code 5 (scaled index): the address equals base plus index times 2^scale, where scale is the 3-bit scale code.
- R7: Mode code 6 (scaled index with displacement): the address equals base plus index times 2^scale plus the sign-extended displacement.
- R8: Mode code 7 (PC-relative): the address equals the program counter plus the sign-extended displacement.
- R9: The auto-modify step is 2^size bytes, giving 1, 2, 4 or 8 for the 2-bit size codes 0 to 3.
- R10: A scale code of 5, 6 or 7 sets the error flag for any mode. In that case the write-back strobe is 0 and the address and write-back value are 0. Scale codes 0 to 4 leave the error flag at 0.
- R11: In modes 0, 1 and 4 to 7 the write-back strobe is 0 and the write-back value is 0.
- R12: A request is accepted when in_valid and in_ready are both high. in_ready equals (not out_valid) or out_ready. The result is presented with out_valid on the next cycle. While out_valid is high and out_ready is low, out_valid and all result outputs hold their values.
- R13: After synchronous reset, out_valid, the address, the write-back strobe, the write-back value and the error flag are all 0, and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| mode | input | 3 | Addressing mode code |
| scale | input | 3 | Index scale code (legal range 0 to 4) |
| size | input | 2 | Access size code, step = 2^size bytes |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| disp | input | 16 | Signed displacement |
| abs_addr | input | 32 | Absolute address field |
| pc | input | 32 | Program counter |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| ea | output | 32 | Effective address |
| wb_en | output | 1 | Base write-back strobe |
| wb_val | output | 32 | New base register value |
| err | output | 1 | Illegal scale code |

## Verification
The write-back of an auto-modify mode and the illegal-scale error can meet in a single request. The bench triggers this by sending post-increment and pre-decrement requests with scale codes 5 to 7, both directed and at random. It then checks that the error wins: the strobe is 0, the address and write-back value are 0, and the flag is 1. A second meeting point is a new request arriving while a stalled result is still held. The bench randomizes out_ready alongside in_valid, and in every cycle it compares the held outputs and in_ready with its own model of the output register.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int unsigned EA_AW        = 32;
    localparam int unsigned EA_DW        = 16;
    localparam int unsigned EA_SCALE_W   = 3;
    localparam int unsigned EA_SIZE_W    = 2;
    localparam int unsigned EA_MAX_SHIFT = 4;

    typedef enum logic [2:0] {
        AM_DIRECT   = 3'd0,
        AM_REGIND   = 3'd1,
        AM_POSTINC  = 3'd2,
        AM_PREDEC   = 3'd3,
        AM_DISP     = 3'd4,
        AM_SCALED   = 3'd5,
        AM_SCALED_D = 3'd6,
        AM_PCREL    = 3'd7
    } am_mode_e;

    typedef struct packed {
        am_mode_e                mode;
        logic [EA_SCALE_W-1:0]   scale;
        logic [EA_SIZE_W-1:0]    size;
        logic [EA_AW-1:0]        base;
        logic [EA_AW-1:0]        index;
        logic [EA_DW-1:0]        disp;
        logic [EA_AW-1:0]        abs_addr;
        logic [EA_AW-1:0]        pc;
    } ea_req_t;

    typedef struct packed {
        logic [EA_AW-1:0] ea;
        logic             wb_en;
        logic [EA_AW-1:0] wb_val;
        logic             err;
    } ea_res_t;

    function automatic logic [EA_AW-1:0] sext_disp(input logic [EA_DW-1:0] d);
        return {{(EA_AW-EA_DW){d[EA_DW-1]}}, d};
    endfunction

    function automatic logic is_auto_modify(input am_mode_e m);
        return (m == AM_POSTINC) || (m == AM_PREDEC);
    endfunction

endpackage

// File: rtl/ea_scaler.sv
module ea_scaler
    import ea_pkg::*;
#(
    parameter int unsigned AW        = EA_AW,
    parameter int unsigned SW        = EA_SCALE_W,
    parameter int unsigned MAX_SHIFT = EA_MAX_SHIFT
) (
    input  logic [AW-1:0] idx,
    input  logic [SW-1:0] sel,
    output logic [AW-1:0] scaled,
    output logic          bad
);
    localparam int unsigned NCAND = MAX_SHIFT + 1;

    logic [AW-1:0] cand [NCAND];

    for (genvar k = 0; k < NCAND; k++) begin : g_cand
        assign cand[k] = idx << k;
    end

    always_comb begin
        scaled = '0;
        bad    = 1'b1;
        for (int k = 0; k < NCAND; k++) begin
            if (sel == SW'(k)) begin
                scaled = cand[k];
                bad    = 1'b0;
            end
        end
    end
endmodule

// File: rtl/ea_step_gen.sv
module ea_step_gen
    import ea_pkg::*;
#(
    parameter int unsigned AW = EA_AW,
    parameter int unsigned ZW = EA_SIZE_W
) (
    input  logic [ZW-1:0] size,
    output logic [AW-1:0] step
);
    localparam int unsigned NSTEP = 1 << ZW;

    logic [AW-1:0] tbl [NSTEP];

    for (genvar s = 0; s < NSTEP; s++) begin : g_step
        assign tbl[s] = AW'(1) << s;
    end

    assign step = tbl[size];
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_pkg::*;
(
    input  ea_req_t          req,
    input  logic [EA_AW-1:0] scaled_idx,
    input  logic             scale_bad,
    input  logic [EA_AW-1:0] step,
    output ea_res_t          res
);
    logic [EA_AW-1:0] dx;
    logic [EA_AW-1:0] base_plus_idx;
    logic [EA_AW-1:0] base_inc;
    logic [EA_AW-1:0] base_dec;

    assign dx            = sext_disp(req.disp);
    assign base_plus_idx = req.base + scaled_idx;
    assign base_inc      = req.base + step;
    assign base_dec      = req.base - step;

    always_comb begin
        res = '0;
        if (scale_bad) begin
            res.err = 1'b1;
        end else begin
            unique case (req.mode)
                AM_DIRECT:   res.ea = req.abs_addr;
                AM_REGIND:   res.ea = req.base;
                AM_POSTINC: begin
                    res.ea     = req.base;
                    res.wb_en  = 1'b1;
                    res.wb_val = base_inc;
                end
                AM_PREDEC: begin
                    res.ea     = base_dec;
                    res.wb_en  = 1'b1;
                    res.wb_val = base_dec;
                end
                AM_DISP:     res.ea = req.base + dx;
                AM_SCALED:   res.ea = base_plus_idx;
                AM_SCALED_D: res.ea = base_plus_idx + dx;
                AM_PCREL:    res.ea = req.pc + dx;
                default:     res.ea = '0;
            endcase
        end
    end

    always_comb begin
        if (!scale_bad && !is_auto_modify(req.mode))
            a_nowb_r11: assert (!res.wb_en && res.wb_val == '0);
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [2:0]            mode,
    input  logic [EA_SCALE_W-1:0] scale,
    input  logic [EA_SIZE_W-1:0]  size,
    input  logic [EA_AW-1:0]      base,
    input  logic [EA_AW-1:0]      index,
    input  logic [EA_DW-1:0]      disp,
    input  logic [EA_AW-1:0]      abs_addr,
    input  logic [EA_AW-1:0]      pc,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [EA_AW-1:0]      ea,
    output logic                  wb_en,
    output logic [EA_AW-1:0]      wb_val,
    output logic                  err
);
    ea_req_t          req;
    ea_res_t          res_d;
    ea_res_t          res_q;
    logic             valid_q;
    logic [EA_AW-1:0] scaled_idx;
    logic             scale_bad;
    logic [EA_AW-1:0] step;
    logic             accept;

    assign req.mode     = am_mode_e'(mode);
    assign req.scale    = scale;
    assign req.size     = size;
    assign req.base     = base;
    assign req.index    = index;
    assign req.disp     = disp;
    assign req.abs_addr = abs_addr;
    assign req.pc       = pc;

    ea_scaler u_scaler (
        .idx    (req.index),
        .sel    (req.scale),
        .scaled (scaled_idx),
        .bad    (scale_bad)
    );

    ea_step_gen u_step (
        .size (req.size),
        .step (step)
    );

    ea_addr_calc u_calc (
        .req        (req),
        .scaled_idx (scaled_idx),
        .scale_bad  (scale_bad),
        .step       (step),
        .res        (res_d)
    );

    assign in_ready = !valid_q || out_ready;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else if (accept) begin
            valid_q <= 1'b1;
            res_q   <= res_d;
        end else if (out_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign out_valid = valid_q;
    assign ea        = res_q.ea;
    assign wb_en     = res_q.wb_en;
    assign wb_val    = res_q.wb_val;
    assign err       = res_q.err;

    p_reset_r13: assert property (@(posedge clk)
        rst |=> !out_valid && !wb_en && !err && ea == '0);

    p_accept_r12: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid);

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(ea) && $stable(wb_en)
                                    && $stable(wb_val) && $stable(err));

    p_err_nowb_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && scale > 3'd4 |=> err && !wb_en && ea == '0);

    p_predec_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && mode == 3'd3 && scale <= 3'd4
        |=> wb_en && wb_val == ea);

    p_postinc_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && mode == 3'd2 && scale <= 3'd4
        |=> wb_en && (wb_val - ea) == (EA_AW'(1) << $past(size)));

    p_nowb_r11: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && mode != 3'd2 && mode != 3'd3 |=> !wb_en);
endmodule

// File: tb/sim_ea_gen.sv
module sim_ea_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ready, out_valid, out_ready;
    logic [2:0]  mode, scale;
    logic [1:0]  size;
    logic [31:0] base, index, abs_addr, pc, ea, wb_val;
    logic [15:0] disp;
    logic        wb_en, err;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    // model of the output register
    bit          m_valid;
    logic [31:0] m_ea, m_wb;
    bit          m_we, m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    ea_gen u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .mode(mode), .scale(scale), .size(size), .base(base), .index(index),
        .disp(disp), .abs_addr(abs_addr), .pc(pc), .out_valid(out_valid),
        .out_ready(out_ready), .ea(ea), .wb_en(wb_en), .wb_val(wb_val), .err(err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] m, input bit e);
        if (e) return "R10";
        case (m)
            3'd0: return "R1";  3'd1: return "R2";  3'd2: return "R3/R9";
            3'd3: return "R4/R9"; 3'd4: return "R5"; 3'd5: return "R6";
            3'd6: return "R7";  default: return "R8";
        endcase
    endfunction

    task automatic expect_of(input logic [2:0] m, input logic [2:0] sc, input logic [1:0] sz,
                             input logic [31:0] b, input logic [31:0] ix, input logic [15:0] d,
                             input logic [31:0] ab, input logic [31:0] p,
                             output logic [31:0] e, output logic [31:0] w,
                             output bit we, output bit er);
        logic [31:0] sd, stp, six;
        sd  = 32'($signed(d));
        stp = 32'd1 << sz;
        six = ix * (32'd1 << sc);
        e = 0; w = 0; we = 0; er = 0;
        if (sc > 3'd4) begin
            er = 1;
        end else begin
            case (m)
                3'd0: e = ab;
                3'd1: e = b;
                3'd2: begin e = b; w = b + stp; we = 1; end
                3'd3: begin e = b - stp; w = b - stp; we = 1; end
                3'd4: e = b + sd;
                3'd5: e = b + six;
                3'd6: e = b + six + sd;
                default: e = p + sd;
            endcase
        end
    endtask

    // one cycle: check held state, drive new inputs, update model
    task automatic cyc(input bit v, input bit rdy, input logic [2:0] m, input logic [2:0] sc,
                       input logic [1:0] sz, input logic [31:0] b, input logic [31:0] ix,
                       input logic [15:0] d, input logic [31:0] ab, input logic [31:0] p);
        string t;
        logic [31:0] e, w;
        bit we, er, rd_exp;
        chk("R12 out_valid", 32'(out_valid), 32'(m_valid));
        if (m_valid) begin
            t = "R12/R11";
            chk({t, " ea"}, ea, m_ea);
            chk({t, " wb_en"}, 32'(wb_en), 32'(m_we));
            chk({t, " wb_val"}, wb_val, m_wb);
            chk({t, " err"}, 32'(err), 32'(m_err));
        end
        in_valid = v; out_ready = rdy; mode = m; scale = sc; size = sz;
        base = b; index = ix; disp = d; abs_addr = ab; pc = p;
        #1;
        rd_exp = !m_valid || rdy;
        chk("R12 in_ready", 32'(in_ready), 32'(rd_exp));
        if (v && rd_exp) begin
            expect_of(m, sc, sz, b, ix, d, ab, p, e, w, we, er);
            m_valid = 1; m_ea = e; m_wb = w; m_we = we; m_err = er;
            $sformat(t, "%s mode=%0d", tag_of(m, er), m);
        end else if (rdy) begin
            m_valid = 0;
        end
        @(negedge clk);
        if (m_valid && v && rd_exp) begin
            chk({t, " ea"}, ea, m_ea);
            chk({t, " wb_en"}, 32'(wb_en), 32'(m_we));
            chk({t, " wb_val"}, wb_val, m_wb);
            chk({t, " err"}, 32'(err), 32'(m_err));
        end
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=%0d expected<=100000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin : main
        void'($urandom(32'h1234_5678));
        rst = 1; in_valid = 0; out_ready = 1; mode = 0; scale = 0; size = 0;
        base = 0; index = 0; disp = 0; abs_addr = 0; pc = 0;
        m_valid = 0; m_ea = 0; m_wb = 0; m_we = 0; m_err = 0;
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 out_valid", 32'(out_valid), 0);
        chk("R13 ea", ea, 0);
        chk("R13 wb_en", 32'(wb_en), 0);
        chk("R13 wb_val", wb_val, 0);
        chk("R13 err", 32'(err), 0);
        chk("R13 in_ready", 32'(in_ready), 1);
        rst = 0;
        @(negedge clk);

        // directed corners
        cyc(1,1,3'd0,3'd0,2'd0,32'h1111_0000,32'h0,16'h0,32'hCAFE_F00D,32'h0);          // R1
        cyc(1,1,3'd1,3'd0,2'd0,32'h0000_4000,32'h0,16'h0,32'h0,32'h0);                  // R2
        for (int s = 0; s < 4; s++)                                                      // R3 R9
            cyc(1,1,3'd2,3'd0,2'(s),32'hFFFF_FFFE,32'h0,16'h0,32'h0,32'h0);
        for (int s = 0; s < 4; s++)                                                      // R4 R9 wrap
            cyc(1,1,3'd3,3'd0,2'(s),32'h0000_0002,32'h0,16'h0,32'h0,32'h0);
        cyc(1,1,3'd4,3'd0,2'd0,32'h0000_0010,32'h0,16'h8000,32'h0,32'h0);              // R5 neg
        cyc(1,1,3'd4,3'd0,2'd0,32'hFFFF_FFF0,32'h0,16'h7FFF,32'h0,32'h0);              // R5 wrap
        for (int s = 0; s < 5; s++)                                                      // R6
            cyc(1,1,3'd5,3'(s),2'd0,32'h100,32'h0000_0003,16'h0,32'h0,32'h0);
        cyc(1,1,3'd6,3'd4,2'd0,32'h1000,32'h1000_0001,16'hFFFC,32'h0,32'h0);           // R7
        cyc(1,1,3'd7,3'd0,2'd0,32'h0,32'h0,16'hFFFE,32'h0,32'h0000_0000);              // R8 wrap
        for (int s = 5; s < 8; s++) begin                                                // R10 with R3/R4
            cyc(1,1,3'd2,3'(s),2'd3,32'h500,32'h7,16'h4,32'h9,32'h9);
            cyc(1,1,3'd3,3'(s),2'd1,32'h500,32'h7,16'h4,32'h9,32'h9);
            cyc(1,1,3'd6,3'(s),2'd1,32'h500,32'h7,16'h4,32'h9,32'h9);
        end
        // R12 stall: hold result, then new request while stalled
        cyc(1,0,3'd2,3'd0,2'd2,32'h2000,32'h0,16'h0,32'h0,32'h0);
        cyc(1,0,3'd1,3'd0,2'd0,32'h3000,32'h0,16'h0,32'h0,32'h0);
        cyc(0,0,3'd1,3'd0,2'd0,32'h3000,32'h0,16'h0,32'h0,32'h0);
        cyc(1,1,3'd7,3'd0,2'd0,32'h0,32'h0,16'h0010,32'h0,32'h8000_0000);
        cyc(0,1,3'd0,3'd0,2'd0,32'h0,32'h0,16'h0,32'h0,32'h0);

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            bit v, r;
            logic [2:0] sc;
            v  = ($urandom % 4) != 0;
            r  = ($urandom % 4) != 0;
            sc = (($urandom % 8) == 0) ? 3'(5 + $urandom % 3) : 3'($urandom % 5);
            cyc(v, r, 3'($urandom), sc, 2'($urandom), $urandom, $urandom,
                16'($urandom), $urandom, $urandom);
        end
        cyc(0,1,3'd0,3'd0,2'd0,32'h0,32'h0,16'h0,32'h0,32'h0);
        cyc(0,1,3'd0,3'd0,2'd0,32'h0,32'h0,16'h0,32'h0,32'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule